// File: doc/BRIEF.md
# Shift and Rotate Unit

This unit performs the eight-way family of shift and rotate operations used by a 16-bit processor's integer datapath, on either a byte (low half) or a full word operand. A request is started with a one-cycle `start_i` pulse. The request carries the operand, a width select, a 3-bit operation code, the incoming carry and overflow flags, and a count. The count is either the fixed value one or taken from an 8-bit count input.

The unit moves the operand one bit position per clock. The first position is applied on the same edge that accepts the request. While more positions remain, `busy_o` is high. When the last position has been applied, `done_o` pulses for one cycle, and the result, carry and overflow stay on the outputs until the next request.

A request that carries the reserved operation code is not executed. It raises `illegal_o` for one cycle instead. Operand fetch, writeback, the zero, sign and parity flags, and instruction decode all belong to the surrounding pipeline.

Top module: `srot_unit`

## Requirements
- R1: Operation code 0 rotates left: every bit moves up one place, the old top bit enters bit 0 and also becomes the carry. Code 1 rotates right: the old bit 0 enters the top bit and also becomes the carry.
- R2: Code 2 rotates left through carry: the incoming carry enters bit 0 and the old top bit becomes the carry. Code 3 rotates right through carry: the incoming carry enters the top bit and the old bit 0 becomes the carry.
- R3: Code 4 shifts left, filling bit 0 with 0, and the old top bit becomes the carry. Code 5 shifts right, filling the top bit with 0, and the old bit 0 becomes the carry.
- R4: Code 7 shifts right arithmetically: the top bit is copied into itself, the old bit 0 becomes the carry, and the overflow flag is 0.
- R5: For codes 0, 2 and 4, each position sets the overflow flag to the XOR of the top bit and the next-lower bit of the value before that position.
- R6: Each position sets the overflow flag as follows. For code 1 it is the new carry XOR the bit just below the top bit of the value before the position. For code 3 it is the incoming carry XOR the old top bit. For code 5 it is the old top bit.
- R7: With `wide_i`=0, only bits 7..0 take part: the top bit is bit 7, the next-lower bit is bit 6, and `result_o[15:8]` is 0. With `wide_i`=1, all 16 bits take part, with top bits 15 and 14.
- R8: The effective count N is `cnt_i` when `use_cnt_i`=1 and 1 otherwise. For N≥1, `done_o` is high only in the cycle after the N-th rising edge, counting the edge that samples `start_i` as the first. `busy_o` is high after edges 1 to N-1. The final carry and overflow come from the last position.
- R9: With N=0, `done_o` is high after the first edge. The result equals the operand, limited to the selected width, and the carry and overflow outputs equal `carry_i` and `ovf_i`.
- R10: Code 6 raises `illegal_o` for exactly one cycle after the sampling edge. It does not raise `done_o` or `busy_o`, and it leaves the result and flags unchanged.
- R11: `start_i` is ignored while `busy_o` is high.
- R12: After reset, the result, carry, overflow, `busy_o`, `done_o` and `illegal_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept a request this cycle |
| wide_i | input | 1 | 1 = word operand, 0 = byte operand |
| op_i | input | 3 | Operation code |
| use_cnt_i | input | 1 | 1 = count from `cnt_i`, 0 = count of one |
| cnt_i | input | 8 | Count value |
| operand_i | input | 16 | Operand |
| carry_i | input | 1 | Incoming carry flag |
| ovf_i | input | 1 | Incoming overflow flag |
| result_o | output | 16 | Shifted or rotated value |
| carry_o | output | 1 | Resulting carry flag |
| overflow_o | output | 1 | Resulting overflow flag |
| busy_o | output | 1 | Positions still remain to be applied |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle reserved-code pulse |

## Verification
Every legal code is swept over both widths, both incoming carry values and eight counts (0, 1, 2, 3, 8, 9, 16, 17). The operands are chosen so that each pair of top bits and each bit-0 value occur. Counts of 8, 9, 16 and 17 separate plain rotation from rotation through carry, because only the carry form has a period one longer than the width. Operands whose two top bits differ separate the overflow rules of each code from one another. The incoming overflow is set to the inverse of the incoming carry, so a zero count that passes the wrong input flag is caught.

Further directed cases cover four behaviours: the fixed-one form with a nonzero count input, a start pulse issued while busy, the reserved code, and the state right after reset.

// File: rtl/srot_pkg.sv
package srot_pkg;

    typedef enum logic [2:0] {
        OP_ROL = 3'd0,
        OP_ROR = 3'd1,
        OP_RCL = 3'd2,
        OP_RCR = 3'd3,
        OP_SHL = 3'd4,
        OP_SHR = 3'd5,
        OP_RSV = 3'd6,
        OP_SAR = 3'd7
    } srot_op_e;

endpackage

// File: rtl/srot_step.sv
// One bit position of shift or rotate on a W-bit value.
module srot_step
    import srot_pkg::*;
#(
    parameter int W = 16
) (
    input  srot_op_e       op_i,
    input  logic [W-1:0]   val_i,
    input  logic           cin_i,
    output logic [W-1:0]   val_o,
    output logic           cout_o,
    output logic           ovf_o
);

    logic top_bit;
    logic sub_bit;
    logic low_bit;

    assign top_bit = val_i[W-1];
    assign sub_bit = val_i[W-2];
    assign low_bit = val_i[0];

    always_comb begin
        val_o  = val_i;
        cout_o = cin_i;
        ovf_o  = 1'b0;
        unique case (op_i)
            OP_ROL: begin
                val_o  = {val_i[W-2:0], top_bit};
                cout_o = top_bit;
                ovf_o  = top_bit ^ sub_bit;
            end
            OP_ROR: begin
                val_o  = {low_bit, val_i[W-1:1]};
                cout_o = low_bit;
                ovf_o  = low_bit ^ sub_bit;
            end
            OP_RCL: begin
                val_o  = {val_i[W-2:0], cin_i};
                cout_o = top_bit;
                ovf_o  = top_bit ^ sub_bit;
            end
            OP_RCR: begin
                val_o  = {cin_i, val_i[W-1:1]};
                cout_o = low_bit;
                ovf_o  = cin_i ^ top_bit;
            end
            OP_SHL: begin
                val_o  = {val_i[W-2:0], 1'b0};
                cout_o = top_bit;
                ovf_o  = top_bit ^ sub_bit;
            end
            OP_SHR: begin
                val_o  = {1'b0, val_i[W-1:1]};
                cout_o = low_bit;
                ovf_o  = top_bit;
            end
            OP_SAR: begin
                val_o  = {top_bit, val_i[W-1:1]};
                cout_o = low_bit;
                ovf_o  = 1'b0;
            end
            default: begin
                val_o  = val_i;
                cout_o = cin_i;
                ovf_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/srot_datapath.sv
// Half-width and full-width step lanes, selected by the width input.
module srot_datapath
    import srot_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  srot_op_e            op_i,
    input  logic                wide_i,
    input  logic [DATA_W-1:0]   val_i,
    input  logic                cin_i,
    output logic [DATA_W-1:0]   val_o,
    output logic                cout_o,
    output logic                ovf_o
);

    localparam int NLANE = 2;

    logic [DATA_W-1:0] lane_val [NLANE];
    logic              lane_c   [NLANE];
    logic              lane_o   [NLANE];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = (g == 0) ? DATA_W / 2 : DATA_W;
        logic [LW-1:0] step_val;

        srot_step #(.W(LW)) u_step (
            .op_i   (op_i),
            .val_i  (val_i[LW-1:0]),
            .cin_i  (cin_i),
            .val_o  (step_val),
            .cout_o (lane_c[g]),
            .ovf_o  (lane_o[g])
        );

        assign lane_val[g] = DATA_W'(step_val);
    end

    always_comb begin
        val_o  = wide_i ? lane_val[1] : lane_val[0];
        cout_o = wide_i ? lane_c[1]   : lane_c[0];
        ovf_o  = wide_i ? lane_o[1]   : lane_o[0];
    end

endmodule

// File: rtl/srot_unit.sv
module srot_unit
    import srot_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wide_i,
    input  logic [2:0]        op_i,
    input  logic              use_cnt_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              carry_i,
    input  logic              ovf_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              overflow_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              illegal_o
);

    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic              cf;
        logic              of;
        logic [CNT_W-1:0]  rem;
        srot_op_e          op;
        logic              wide;
        logic              done;
        logic              illegal;
    } state_t;

    state_t s_d, s_q;

    srot_op_e          req_op;
    logic [CNT_W-1:0]  eff_cnt;
    logic [DATA_W-1:0] req_val;
    logic              running;

    srot_op_e          dp_op;
    logic              dp_wide;
    logic [DATA_W-1:0] dp_val;
    logic              dp_cin;
    logic [DATA_W-1:0] dp_val_o;
    logic              dp_c_o;
    logic              dp_o_o;

    assign req_op  = srot_op_e'(op_i);
    assign eff_cnt = use_cnt_i ? cnt_i : CNT_W'(1);
    assign req_val = wide_i ? operand_i : DATA_W'(operand_i[HALF_W-1:0]);
    assign running = (s_q.rem != '0);

    // The datapath works on held state while running, otherwise on the request.
    always_comb begin
        dp_op   = running ? s_q.op   : req_op;
        dp_wide = running ? s_q.wide : wide_i;
        dp_val  = running ? s_q.val  : req_val;
        dp_cin  = running ? s_q.cf   : carry_i;
    end

    srot_datapath #(.DATA_W(DATA_W)) u_datapath (
        .op_i   (dp_op),
        .wide_i (dp_wide),
        .val_i  (dp_val),
        .cin_i  (dp_cin),
        .val_o  (dp_val_o),
        .cout_o (dp_c_o),
        .ovf_o  (dp_o_o)
    );

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.illegal = 1'b0;
        if (running) begin
            s_d.val  = dp_val_o;
            s_d.cf   = dp_c_o;
            s_d.of   = dp_o_o;
            s_d.rem  = s_q.rem - CNT_W'(1);
            s_d.done = (s_q.rem == CNT_W'(1));
        end else if (start_i) begin
            if (req_op == OP_RSV) begin
                s_d.illegal = 1'b1;
            end else begin
                s_d.op   = req_op;
                s_d.wide = wide_i;
                if (eff_cnt == '0) begin
                    s_d.val  = req_val;
                    s_d.cf   = carry_i;
                    s_d.of   = ovf_i;
                    s_d.rem  = '0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.val  = dp_val_o;
                    s_d.cf   = dp_c_o;
                    s_d.of   = dp_o_o;
                    s_d.rem  = eff_cnt - CNT_W'(1);
                    s_d.done = (eff_cnt == CNT_W'(1));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{val: '0, cf: 1'b0, of: 1'b0, rem: '0, op: OP_ROL,
                     wide: 1'b0, done: 1'b0, illegal: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign result_o   = s_q.val;
    assign carry_o    = s_q.cf;
    assign overflow_o = s_q.of;
    assign busy_o     = running;
    assign done_o     = s_q.done;
    assign illegal_o  = s_q.illegal;

    // R8: completion never overlaps remaining work
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8: one bit position per clock
    p_one_per_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (s_q.rem == CNT_W'($past(s_q.rem) - CNT_W'(1))));

    // R11: a running request keeps its operation and width
    p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(s_q.op) && $stable(s_q.wide)));

    // R4: arithmetic right shift ends with overflow cleared
    p_sar_ovf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && s_q.op == OP_SAR) |=> !overflow_o);

    // R7: byte results carry nothing in the upper half
    p_byte_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !s_q.wide) |-> (result_o[DATA_W-1:HALF_W] == '0));

    // R10: reserved code never completes or runs
    p_illegal_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!done_o && !busy_o));

    // R9: a zero count passes the incoming flags through
    p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i != 3'd6 && eff_cnt == '0) |=>
        (done_o && carry_o == $past(carry_i) && overflow_o == $past(ovf_i)));

endmodule

// File: tb/srot_unit_bench.sv
module srot_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        wide_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic        use_cnt_i = 1'b0;
    logic [7:0]  cnt_i = 8'd0;
    logic [15:0] operand_i = 16'd0;
    logic        carry_i = 1'b0;
    logic        ovf_i = 1'b0;
    logic [15:0] result_o;
    logic        carry_o;
    logic        overflow_o;
    logic        busy_o;
    logic        done_o;
    logic        illegal_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    srot_unit u_srot_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .wide_i     (wide_i),
        .op_i       (op_i),
        .use_cnt_i  (use_cnt_i),
        .cnt_i      (cnt_i),
        .operand_i  (operand_i),
        .carry_i    (carry_i),
        .ovf_i      (ovf_i),
        .result_o   (result_o),
        .carry_o    (carry_o),
        .overflow_o (overflow_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .illegal_o  (illegal_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Arithmetic model of N positions.
    task automatic model(input int op, input bit wide, input int opnd,
                         input int ci, input int oi, input int n,
                         output int r, output int c, output int o);
        int w;
        int mask;
        int v;
        int msb;
        int nxt;
        int lsb;
        w    = wide ? 16 : 8;
        mask = (1 << w) - 1;
        v    = opnd & mask;
        c    = ci;
        o    = oi;
        for (int k = 0; k < n; k++) begin
            msb = (v >> (w - 1)) & 1;
            nxt = (v >> (w - 2)) & 1;
            lsb = v & 1;
            case (op)
                0: begin v = ((v << 1) | msb) & mask;          o = msb ^ nxt; c = msb; end
                1: begin v = (v >> 1) | (lsb << (w - 1));      o = lsb ^ nxt; c = lsb; end
                2: begin v = ((v << 1) | c) & mask;            o = msb ^ nxt; c = msb; end
                3: begin v = (v >> 1) | (c << (w - 1));        o = c ^ msb;   c = lsb; end
                4: begin v = (v << 1) & mask;                  o = msb ^ nxt; c = msb; end
                5: begin v = v >> 1;                           o = msb;       c = lsb; end
                7: begin v = (v >> 1) | (msb << (w - 1));      o = 0;         c = lsb; end
                default: ;
            endcase
        end
        r = v;
    endtask

    function automatic string op_req(input int op);
        case (op)
            0, 1: return "R1";
            2, 3: return "R2";
            4, 5: return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic string ovf_req(input int op);
        case (op)
            0, 2, 4: return "R5";
            1, 3, 5: return "R6";
            default: return "R4";
        endcase
    endfunction

    task automatic run_op(input int op, input bit wide, input int opnd,
                          input bit ci, input bit use_cnt, input int cnt);
        int n;
        int er;
        int ec;
        int eo;
        int cyc;
        string rq;
        n = use_cnt ? cnt : 1;
        model(op, wide, opnd, int'(ci), int'(!ci), n, er, ec, eo);
        rq = (n == 0) ? "R9" : op_req(op);
        @(negedge clk);
        op_i      = 3'(op);
        wide_i    = wide;
        operand_i = 16'(opnd);
        carry_i   = ci;
        ovf_i     = !ci;
        use_cnt_i = use_cnt;
        cnt_i     = 8'(cnt);
        start_i   = 1'b1;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        cyc = 1;
        if (n >= 2) chk(busy_o == 1'b1, "R8", "busy after first edge", int'(busy_o), 1);
        while (!done_o && cyc < 300) begin
            @(posedge clk);
            #1;
            cyc++;
        end
        chk(cyc == ((n == 0) ? 1 : n), "R8", "cycles to done", cyc, (n == 0) ? 1 : n);
        chk(int'(result_o) == er, rq, "result", int'(result_o), er);
        chk(int'(carry_o) == ec, rq, "carry", int'(carry_o), ec);
        chk(int'(overflow_o) == eo, (n == 0) ? "R9" : ovf_req(op), "overflow",
            int'(overflow_o), eo);
        if (!wide) chk(result_o[15:8] == 8'h00, "R7", "byte upper half", int'(result_o[15:8]), 0);
        @(posedge clk);
        #1;
        chk(done_o == 1'b0, "R8", "done single pulse", int'(done_o), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R8 watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int ops[7];
        int pats[8];
        int cnts[8];
        int held_r;
        int held_c;
        int held_o;
        ops  = '{0, 1, 2, 3, 4, 5, 7};
        pats = '{16'h0000, 16'hFFFF, 16'h8001, 16'h4040, 16'hA5C3, 16'h1234, 16'hC07F, 16'h7F80};
        cnts = '{0, 1, 2, 3, 8, 9, 16, 17};

        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        chk(result_o == 16'h0, "R12", "reset result", int'(result_o), 0);
        chk({carry_o, overflow_o} == 2'b00, "R12", "reset flags", int'({carry_o, overflow_o}), 0);
        chk({busy_o, done_o, illegal_o} == 3'b000, "R12", "reset status",
            int'({busy_o, done_o, illegal_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int oi = 0; oi < 7; oi++)
            for (int w = 0; w < 2; w++)
                for (int p = 0; p < 8; p++)
                    for (int c = 0; c < 2; c++)
                        for (int k = 0; k < 8; k++)
                            run_op(ops[oi], w[0], pats[p], c[0], 1'b1, cnts[k]);

        // R8: fixed form ignores the count value
        run_op(0, 1'b1, 16'h8421, 1'b0, 1'b0, 5);
        run_op(3, 1'b0, 16'h00C3, 1'b1, 1'b0, 200);

        // R11: start while busy is ignored
        @(negedge clk);
        op_i = 3'd0; wide_i = 1'b1; operand_i = 16'h8003; carry_i = 1'b0; ovf_i = 1'b0;
        use_cnt_i = 1'b1; cnt_i = 8'd5; start_i = 1'b1;
        @(negedge clk);
        op_i = 3'd5; operand_i = 16'hFFFF; cnt_i = 8'd1; carry_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        chk(result_o == 16'h0070, "R11", "result of first request", int'(result_o), 16'h0070);
        chk(carry_o == 1'b0, "R11", "carry of first request", int'(carry_o), 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R11", "no second completion", int'(done_o), 0);

        // R10: reserved code
        held_r = int'(result_o);
        held_c = int'(carry_o);
        held_o = int'(overflow_o);
        @(negedge clk);
        op_i = 3'd6; operand_i = 16'h1111; carry_i = 1'b1; ovf_i = 1'b1; start_i = 1'b1;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        chk(illegal_o == 1'b1, "R10", "illegal raised", int'(illegal_o), 1);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R10", "no done or busy",
            int'({done_o, busy_o}), 0);
        chk(int'(result_o) == held_r, "R10", "result unchanged", int'(result_o), held_r);
        chk(int'(carry_o) == held_c && int'(overflow_o) == held_o, "R10", "flags unchanged",
            int'({carry_o, overflow_o}), (held_c << 1) | held_o);
        @(posedge clk);
        #1;
        chk(illegal_o == 1'b0, "R10", "illegal single pulse", int'(illegal_o), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule